// File: doc/BRIEF.md
# Dual-Issue Pairing Check

This block sits at the head of an in-order fetch window. Each cycle it looks at the two oldest decoded instructions and decides how many of them can leave together: none, the older one alone, or both. The machine has one integer-side issue slot and one floating-point-side issue slot. FP loads and FP stores need address arithmetic, so they take the integer slot. Only FP arithmetic uses the FP slot.

The decision uses the two opcode classes and all six register specifiers (two destinations and four sources). It also uses a busy-bit vector for each register file, which stands in for a scoreboard of older in-flight work.

A pair can issue only when its two instructions sit on opposite sides and neither depends on the other. The only dependencies that cross the split come from an FP load or FP store in the integer slot. The older instruction never waits on the younger one, and the younger one never issues without the older one.

The block drives per-slot enables and a steering bit for the integer slot. It also registers the issue count, and the fetch window uses that registered value to shift by 0, 1 or 2 entries. In the best case two instructions issue every cycle, for a CPI of 0.5. That needs an exact half-and-half mix of integer-side and FP-side work with no hazards.

Top module: `pair_issue_check`

## Requirements
- R1: The older instruction issues exactly when it is valid and none of the source operands its class reads has its busy bit set. Class encoding: 0 = integer op (dst, src_a and src_b all integer), 1 = FP op (dst, src_a and src_b all FP), 2 = FP load (src_a integer base, dst FP, src_b unused), 3 = FP store (src_a integer base, src_b FP data, no destination).
- R2: The younger instruction issues only in a cycle in which the older one also issues.
- R3: The younger instruction is held back when both instructions belong to the same side. Classes 0, 2 and 3 are integer-side; class 1 is FP-side.
- R4: The younger instruction is held back when it is not valid, or when one of the sources its class reads is busy.
- R5: The younger instruction is held back when the older one is an FP load whose destination equals src_a or src_b of a younger FP op.
- R6: The younger instruction is held back when the older one is an FP op whose destination equals the src_b (store data) of a younger FP store.
- R7: The younger instruction is held back when both instructions write FP registers (an FP load paired with an FP op, in either order) and their destination indices are equal.
- R8: An integer-op destination index that equals an FP operand index of the other instruction has no effect on pairing, because the two indices refer to different register files.
- R9: int_en_o is high when an integer-side instruction issues, and fp_en_o is high when an FP-side instruction issues. int_sel_o is 1 when the younger instruction takes the integer slot and 0 otherwise.
- R10: issue_cnt_o equals the number of instructions issuing this cycle (0, 1 or 2). shift_o shows the previous cycle's count.
- R11: While reset is asserted, shift_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid0_i | input | 1 | Older instruction present |
| cls0_i | input | 2 | Older instruction class |
| dst0_i | input | IW | Older destination index |
| srca0_i | input | IW | Older source A index |
| srcb0_i | input | IW | Older source B index |
| valid1_i | input | 1 | Younger instruction present |
| cls1_i | input | 2 | Younger instruction class |
| dst1_i | input | IW | Younger destination index |
| srca1_i | input | IW | Younger source A index |
| srcb1_i | input | IW | Younger source B index |
| busy_int_i | input | NREG | Integer register busy bits |
| busy_fp_i | input | NREG | FP register busy bits |
| issue0_o | output | 1 | Older instruction issues |
| issue1_o | output | 1 | Younger instruction issues |
| issue_cnt_o | output | 2 | Number issuing this cycle |
| int_en_o | output | 1 | Integer slot in use |
| fp_en_o | output | 1 | FP slot in use |
| int_sel_o | output | 1 | Integer slot fed from younger instruction |
| shift_o | output | 2 | Registered window shift amount |

## Verification
Several hold-back causes for the younger instruction can occur in the same cycle. A busy source can coincide with an FP-load-to-FP-op forwarding conflict or a same-destination write, and a side clash can coincide with matching register indices. The sweep provokes these overlaps by driving every class pair across every 0/1 assignment of the six specifiers while selected busy bits are set. The bench judges each case against its own arithmetic model, so a missing term or a wrong side mapping shows up as a wrong issue count or wrong slot enables. The registered shift is compared one cycle later with the count the bench expected for the previous vector.

// File: rtl/pair_pkg.sv
package pair_pkg;
  typedef enum logic [1:0] {
    CLS_INT  = 2'd0,
    CLS_FPOP = 2'd1,
    CLS_FLD  = 2'd2,
    CLS_FST  = 2'd3
  } op_cls_e;

  function automatic logic fp_side(op_cls_e c);
    return c == CLS_FPOP;
  endfunction

  function automatic logic a_is_fp(op_cls_e c);
    return c == CLS_FPOP;
  endfunction

  function automatic logic b_used(op_cls_e c);
    return c != CLS_FLD;
  endfunction

  function automatic logic b_is_fp(op_cls_e c);
    return (c == CLS_FPOP) || (c == CLS_FST);
  endfunction

  function automatic logic writes_fp(op_cls_e c);
    return (c == CLS_FPOP) || (c == CLS_FLD);
  endfunction
endpackage

// File: rtl/pair_src_check.sv
module pair_src_check
  import pair_pkg::*;
#(
  parameter int NREG = 8,
  localparam int IW = $clog2(NREG)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [1:0]      cls_i,
  input  logic [IW-1:0]   srca_i,
  input  logic [IW-1:0]   srcb_i,
  input  logic [NREG-1:0] busy_int_i,
  input  logic [NREG-1:0] busy_fp_i,
  output logic            ready_o
);
  op_cls_e cls;
  logic    a_busy, b_busy;

  assign cls    = op_cls_e'(cls_i);
  assign a_busy = a_is_fp(cls) ? busy_fp_i[srca_i] : busy_int_i[srca_i];
  assign b_busy = b_used(cls) &&
                  (b_is_fp(cls) ? busy_fp_i[srcb_i] : busy_int_i[srcb_i]);
  assign ready_o = valid_i && !a_busy && !b_busy;

  // R1
  ready_needs_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> valid_i);
  // R1
  int_op_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && cls == CLS_INT) |-> (!busy_int_i[srca_i] && !busy_int_i[srcb_i]));
  // R1
  fst_data_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && cls == CLS_FST) |-> !busy_fp_i[srcb_i]);
endmodule

// File: rtl/pair_xdep.sv
module pair_xdep
  import pair_pkg::*;
#(
  parameter int IW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    cls0_i,
  input  logic [IW-1:0] dst0_i,
  input  logic [1:0]    cls1_i,
  input  logic [IW-1:0] dst1_i,
  input  logic [IW-1:0] srca1_i,
  input  logic [IW-1:0] srcb1_i,
  output logic          conflict_o
);
  op_cls_e c0, c1;
  logic    same_side, raw, waw;

  assign c0 = op_cls_e'(cls0_i);
  assign c1 = op_cls_e'(cls1_i);

  assign same_side = fp_side(c0) == fp_side(c1);
  // only FP registers can be shared across the split
  assign raw = writes_fp(c0) &&
               ((a_is_fp(c1) && dst0_i == srca1_i) ||
                (b_is_fp(c1) && dst0_i == srcb1_i));
  assign waw = writes_fp(c0) && writes_fp(c1) && (dst0_i == dst1_i);

  assign conflict_o = same_side || raw || waw;

  // R5
  fld_raw_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c0 == CLS_FLD && c1 == CLS_FPOP && (dst0_i == srca1_i || dst0_i == srcb1_i))
      |-> conflict_o);
  // R6
  fst_raw_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c0 == CLS_FPOP && c1 == CLS_FST && dst0_i == srcb1_i) |-> conflict_o);
  // R8
  int_dst_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c0 == CLS_INT && c1 == CLS_FPOP) |-> !conflict_o);
endmodule

// File: rtl/pair_issue_check.sv
module pair_issue_check
  import pair_pkg::*;
#(
  parameter int NREG = 8,
  localparam int IW = $clog2(NREG)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid0_i,
  input  logic [1:0]      cls0_i,
  input  logic [IW-1:0]   dst0_i,
  input  logic [IW-1:0]   srca0_i,
  input  logic [IW-1:0]   srcb0_i,
  input  logic            valid1_i,
  input  logic [1:0]      cls1_i,
  input  logic [IW-1:0]   dst1_i,
  input  logic [IW-1:0]   srca1_i,
  input  logic [IW-1:0]   srcb1_i,
  input  logic [NREG-1:0] busy_int_i,
  input  logic [NREG-1:0] busy_fp_i,
  output logic            issue0_o,
  output logic            issue1_o,
  output logic [1:0]      issue_cnt_o,
  output logic            int_en_o,
  output logic            fp_en_o,
  output logic            int_sel_o,
  output logic [1:0]      shift_o
);
  localparam int NSLOT = 2;

  logic            vld  [NSLOT];
  logic [1:0]      cls  [NSLOT];
  logic [IW-1:0]   srca [NSLOT];
  logic [IW-1:0]   srcb [NSLOT];
  logic [NSLOT-1:0] rdy;
  logic            conflict;
  logic            fp0, fp1;

  assign vld[0]  = valid0_i;  assign vld[1]  = valid1_i;
  assign cls[0]  = cls0_i;    assign cls[1]  = cls1_i;
  assign srca[0] = srca0_i;   assign srca[1] = srca1_i;
  assign srcb[0] = srcb0_i;   assign srcb[1] = srcb1_i;

  for (genvar g = 0; g < NSLOT; g++) begin : g_src
    pair_src_check #(.NREG(NREG)) u_src (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .valid_i    (vld[g]),
      .cls_i      (cls[g]),
      .srca_i     (srca[g]),
      .srcb_i     (srcb[g]),
      .busy_int_i (busy_int_i),
      .busy_fp_i  (busy_fp_i),
      .ready_o    (rdy[g])
    );
  end

  pair_xdep #(.IW(IW)) u_xdep (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cls0_i     (cls0_i),
    .dst0_i     (dst0_i),
    .cls1_i     (cls1_i),
    .dst1_i     (dst1_i),
    .srca1_i    (srca1_i),
    .srcb1_i    (srcb1_i),
    .conflict_o (conflict)
  );

  assign fp0 = fp_side(op_cls_e'(cls0_i));
  assign fp1 = fp_side(op_cls_e'(cls1_i));

  assign issue0_o    = rdy[0];
  assign issue1_o    = rdy[0] && rdy[1] && !conflict;
  assign issue_cnt_o = issue1_o ? 2'd2 : (issue0_o ? 2'd1 : 2'd0);
  assign int_en_o    = (issue0_o && !fp0) || (issue1_o && !fp1);
  assign fp_en_o     = (issue0_o && fp0) || (issue1_o && fp1);
  assign int_sel_o   = issue1_o && !fp1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) shift_o <= 2'd0;
    else         shift_o <= issue_cnt_o;
  end

  // R2
  in_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue1_o |-> issue0_o);
  // R3
  split_sides_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue1_o |-> (fp0 != fp1));
  // R9
  one_per_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue1_o |-> (int_en_o && fp_en_o));
  // R10
  shift_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> shift_o == $past(issue_cnt_o));
  // R7
  waw_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue1_o && (cls0_i == 2'd2 || cls0_i == 2'd1) && (cls1_i == 2'd2 || cls1_i == 2'd1))
      |-> dst0_i != dst1_i);
endmodule

// File: tb/pair_issue_check_tb.sv
module pair_issue_check_tb;
  localparam int NREG = 4;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic valid0, valid1;
  logic [1:0] cls0, cls1;
  logic [IW-1:0] dst0, srca0, srcb0, dst1, srca1, srcb1;
  logic [NREG-1:0] busy_int, busy_fp;
  logic issue0, issue1, int_en, fp_en, int_sel;
  logic [1:0] issue_cnt, shift;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pair_issue_check #(.NREG(NREG)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .valid0_i(valid0), .cls0_i(cls0), .dst0_i(dst0), .srca0_i(srca0), .srcb0_i(srcb0),
    .valid1_i(valid1), .cls1_i(cls1), .dst1_i(dst1), .srca1_i(srca1), .srcb1_i(srcb1),
    .busy_int_i(busy_int), .busy_fp_i(busy_fp),
    .issue0_o(issue0), .issue1_o(issue1), .issue_cnt_o(issue_cnt),
    .int_en_o(int_en), .fp_en_o(fp_en), .int_sel_o(int_sel), .shift_o(shift)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (c0=%0d c1=%0d v=%0d%0d)",
               req, act, exp, cls0, cls1, valid0, valid1);
    end
  endtask

  // busy test of one instruction, by class: 0 int,1 fp op,2 fp load,3 fp store
  function automatic bit src_busy(input int c, input int a, input int b,
                                  input logic [NREG-1:0] bi, input logic [NREG-1:0] bf);
    case (c)
      0: return bi[a] | bi[b];
      1: return bf[a] | bf[b];
      2: return bi[a];
      default: return bi[a] | bf[b];
    endcase
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stim
    int prev_cnt;
    valid0 = 0; valid1 = 0; cls0 = 0; cls1 = 0;
    dst0 = 0; srca0 = 0; srcb0 = 0; dst1 = 0; srca1 = 0; srcb1 = 0;
    busy_int = 0; busy_fp = 0;
    repeat (2) @(negedge clk);
    // R11
    chk("R11 shift in reset", shift, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    // R10: invalid pair captured -> 0
    chk("R10 shift after reset", shift, 0);
    prev_cnt = 0;
    for (int c0 = 0; c0 < 4; c0++)
      for (int c1 = 0; c1 < 4; c1++)
        for (int v = 0; v < 4; v++)
          for (int r = 0; r < 64; r++)
            for (int k = 0; k < 8; k++) begin
              bit e0, e1, side_ok, haz, f0, f1;
              int ecnt;
              @(negedge clk);
              // R10
              chk("R10 shift", shift, prev_cnt);
              valid0 = v[0]; valid1 = v[1];
              cls0 = 2'(c0); cls1 = 2'(c1);
              dst0 = 2'(r[0]); srca0 = 2'(r[1]); srcb0 = 2'(r[2]);
              dst1 = 2'(r[3]); srca1 = 2'(r[4]); srcb1 = 2'(r[5]);
              busy_int = (k == 1) ? 4'b0001 : (k == 2) ? 4'b0010 : (k == 5) ? 4'b0011 : 4'b0000;
              busy_fp  = (k == 3) ? 4'b0001 : (k == 4) ? 4'b0010 : (k == 6) ? 4'b0011 : 4'b0000;
              if (k == 7) begin busy_int = 4'b0010; busy_fp = 4'b0001; end
              #2;
              f0 = (c0 == 1); f1 = (c1 == 1);
              // R1
              e0 = v[0] && !src_busy(c0, r[1], r[2], busy_int, busy_fp);
              side_ok = (f0 != f1);
              // R5, R6, R7; R8: int dst never compared with FP operands
              haz = (c0 == 2 && c1 == 1 && (r[0] == r[4] || r[0] == r[5])) ||
                    (c0 == 1 && c1 == 3 && r[0] == r[5]) ||
                    (((c0 == 2 && c1 == 1) || (c0 == 1 && c1 == 2)) && r[0] == r[3]);
              // R2, R3, R4
              e1 = e0 && v[1] && !src_busy(c1, r[4], r[5], busy_int, busy_fp) && side_ok && !haz;
              ecnt = int'(e0) + int'(e1);
              chk("R1 issue0", issue0, e0);
              chk("R2/R3/R4/R5/R6/R7/R8 issue1", issue1, e1);
              chk("R10 count", issue_cnt, ecnt);
              // R9
              chk("R9 int_en", int_en, (e0 && !f0) || (e1 && !f1));
              chk("R9 fp_en", fp_en, (e0 && f0) || (e1 && f1));
              chk("R9 int_sel", int_sel, e1 && !f1);
              prev_cnt = ecnt;
            end
    @(negedge clk);
    chk("R10 final shift", shift, prev_cnt);
    // R11: asynchronous clear
    rst_ni = 1'b0;
    #1;
    chk("R11 async clear", shift, 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule